// File: doc/BRIEF.md
# Pipelined Bit-Level Systolic Unsigned Multiplier

This block multiplies two unsigned N-bit operands with a bit-level systolic array. It accepts a new operand pair on every clock cycle and, once the pipeline has filled, returns one full 2N-bit product on every cycle. Every cell is a registered full adder. It takes one partial-product bit (an AND of one multiplicand bit and one multiplier bit), a sum bit and a carry bit from its neighbours. It passes its sum to the cell of the same weight in the next row and its carry to the next higher weight.

The array has two parts. The first is N carry-save rows, one per multiplier bit. Row r sees the multiplicand after r register delays and multiplier bit r after r register delays, so operand bits meet the matching partial sums. The second is a carry-resolution chain of 2N registered cells, one per product bit. Delay lines skew the carry-save bits in front of this chain and deskew the result bits behind it, so that every bit of a product leaves in the same cycle. A valid flag travels beside the data in a shift register of the same depth. There is no stall: gaps in `in_valid` simply travel through the array as empty slots.

The block is used as a back-end arithmetic stage. The producer raises `in_valid` together with an operand pair. The consumer takes `product` in every cycle where `out_valid` is high. Results leave in the order in which the pairs were accepted.

Top module: `systolic_mult`

## Requirements
- R1: When `out_valid` is high, `product` equals the full unsigned product of the operand pair it belongs to, `op_a * op_b`, as a 2N-bit value with no truncation.
- R2: A pair sampled at rising edge t with `in_valid` high is presented with `out_valid` high directly after rising edge t+3N-1. The latency is therefore exactly 3N register stages: 24 for N = 8.
- R3: With `in_valid` held high for K consecutive cycles, `out_valid` is high for K consecutive cycles, one product per cycle.
- R4: While `rst_n` is low, `out_valid` and `product` are 0. After reset is released, `out_valid` stays low until the first accepted pair has passed the full latency.
- R5: Operand values presented while `in_valid` is low produce no cycle with `out_valid` high in their output slot.
- R6: With `in_valid` gaps interleaved at random, products leave in acceptance order, and each one is in the slot fixed by R2.
- R7: Corner operands are multiplied exactly. The cases are zero, one, the all-ones value (all-ones times all-ones gives 2^(2N) - 2^(N+1) + 1) and the single top bit.
- R8: A valid `product` never exceeds (2^N - 1)^2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every cell registers on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears all cells and the valid line |
| in_valid | input | 1 | The operand pair on this cycle is to be multiplied |
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| out_valid | output | 1 | `product` holds a result in this cycle |
| product | output | 2N | Unsigned product, 2N bits |

## Verification
The array accepts a new pair in the same cycle in which it delivers the product of a pair accepted 3N cycles earlier. It can also carry empty slots holding arbitrary operands next to full ones. The bench provokes both. It runs an unbroken burst, then a stretch of invalid cycles with random operands, then random interleaving of valid and invalid cycles, so that the entry and exit of different pairs overlap in every cycle. A queue model in the bench pushes one entry per rising edge, holding the valid flag and the behaviourally computed product. On every falling edge it compares the oldest entry with `out_valid` and `product`, which judges the slot position, the order and the value together.

// File: rtl/mulsys_pkg.sv
`timescale 1ns/1ps
package mulsys_pkg;

    // Sum output of one full-adder cell.
    function automatic logic fa_sum(input logic x, input logic y, input logic z);
        return x ^ y ^ z;
    endfunction

    // Carry output of one full-adder cell (majority of the three inputs).
    function automatic logic fa_carry(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/mulsys_delay.sv
`timescale 1ns/1ps
// Register delay line of D stages (D must be at least 1).
module mulsys_delay #(
    parameter int W = 1,
    parameter int D = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [D];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < D; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < D; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[D-1];
endmodule

// File: rtl/mulsys_fa_cell.sv
`timescale 1ns/1ps
// Basic systolic cell: full adder with registered sum and carry.
module mulsys_fa_cell
    import mulsys_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic x,
    input  logic y,
    input  logic z,
    output logic sum_q,
    output logic carry_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q   <= 1'b0;
            carry_q <= 1'b0;
        end else begin
            sum_q   <= fa_sum(x, y, z);
            carry_q <= fa_carry(x, y, z);
        end
    end
endmodule

// File: rtl/mulsys_csa_row.sv
`timescale 1ns/1ps
// One carry-save row of the array: adds partial-product row ROW
// (multiplicand AND multiplier bit ROW, weight 2^ROW) to the incoming
// sum/carry vectors, one registered cell per bit weight.
module mulsys_csa_row
    import mulsys_pkg::*;
#(
    parameter int N   = 8,
    parameter int ROW = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   a_i,
    input  logic           b_bit,
    input  logic [2*N-1:0] s_i,
    input  logic [2*N-1:0] c_i,
    output logic [2*N-1:0] s_o,
    output logic [2*N-1:0] c_o
);
    localparam int PW = 2 * N;

    assign c_o[0] = 1'b0;

    for (genvar p = 0; p < PW; p++) begin : g_bit
        logic pp;
        if (p >= ROW && p < ROW + N) begin : g_pp
            assign pp = a_i[p-ROW] & b_bit;
        end else begin : g_nopp
            assign pp = 1'b0;
        end

        if (p < PW - 1) begin : g_cell
            mulsys_fa_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .x       (s_i[p]),
                .y       (c_i[p]),
                .z       (pp),
                .sum_q   (s_o[p]),
                .carry_q (c_o[p+1])
            );
        end else begin : g_top
            // Top weight: the carry would leave the 2N-bit range.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s_o[p] <= 1'b0;
                end else begin
                    s_o[p] <= fa_sum(s_i[p], c_i[p], pp);
                end
            end
        end
    end
endmodule

// File: rtl/systolic_mult.sv
`timescale 1ns/1ps
// Pipelined bit-level systolic unsigned multiplier, latency 3N.
module systolic_mult
    import mulsys_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic           out_valid,
    output logic [2*N-1:0] product
);
    localparam int PW  = 2 * N;
    localparam int LAT = 3 * N;

    // Operand delay elements: row r sees the operands r cycles late.
    logic [N-1:0]  a_d  [N];
    logic          b_sk [N];

    assign a_d[0]  = op_a;
    assign b_sk[0] = op_b[0];

    for (genvar r = 1; r < N; r++) begin : g_skew
        mulsys_delay #(.W(N), .D(1)) u_a_step (
            .clk(clk), .rst_n(rst_n), .d(a_d[r-1]), .q(a_d[r])
        );
        mulsys_delay #(.W(1), .D(r)) u_b_skew (
            .clk(clk), .rst_n(rst_n), .d(op_b[r]), .q(b_sk[r])
        );
    end

    // Carry-save rows.
    logic [PW-1:0] s_row [N+1];
    logic [PW-1:0] c_row [N+1];

    assign s_row[0] = '0;
    assign c_row[0] = '0;

    for (genvar r = 0; r < N; r++) begin : g_row
        mulsys_csa_row #(.N(N), .ROW(r)) u_row (
            .clk   (clk),
            .rst_n (rst_n),
            .a_i   (a_d[r]),
            .b_bit (b_sk[r]),
            .s_i   (s_row[r]),
            .c_i   (c_row[r]),
            .s_o   (s_row[r+1]),
            .c_o   (c_row[r+1])
        );
    end

    // Carry-resolution chain: bit p waits p cycles, meets the carry
    // from bit p-1, then waits 2N-1-p cycles so all bits leave together.
    logic [PW-1:0] cy;
    logic [PW-1:0] res_bit;

    assign cy[0] = 1'b0;

    for (genvar p = 0; p < PW; p++) begin : g_res
        logic [1:0] sc_skewed;

        if (p == 0) begin : g_pre0
            assign sc_skewed = {s_row[N][p], c_row[N][p]};
        end else begin : g_pre
            mulsys_delay #(.W(2), .D(p)) u_pre (
                .clk(clk), .rst_n(rst_n),
                .d({s_row[N][p], c_row[N][p]}), .q(sc_skewed)
            );
        end

        if (p < PW - 1) begin : g_cell
            mulsys_fa_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .x       (sc_skewed[1]),
                .y       (sc_skewed[0]),
                .z       (cy[p]),
                .sum_q   (res_bit[p]),
                .carry_q (cy[p+1])
            );
        end else begin : g_top
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_bit[p] <= 1'b0;
                end else begin
                    res_bit[p] <= fa_sum(sc_skewed[1], sc_skewed[0], cy[p]);
                end
            end
        end

        if (p == PW - 1) begin : g_post0
            assign product[p] = res_bit[p];
        end else begin : g_post
            mulsys_delay #(.W(1), .D(PW - 1 - p)) u_post (
                .clk(clk), .rst_n(rst_n), .d(res_bit[p]), .q(product[p])
            );
        end
    end

    // Valid flag travels beside the data.
    mulsys_delay #(.W(1), .D(LAT)) u_valid (
        .clk(clk), .rst_n(rst_n), .d(in_valid), .q(out_valid)
    );
endmodule

// File: rtl/systolic_mult_check.sv
`timescale 1ns/1ps
module systolic_mult_check #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [N-1:0]   op_a,
    input logic [N-1:0]   op_b,
    input logic           out_valid,
    input logic [2*N-1:0] product
);
    localparam int PW  = 2 * N;
    localparam int LAT = 3 * N;
    localparam logic [PW-1:0] MAX_OP   = {{N{1'b0}}, {N{1'b1}}};
    localparam logic [PW-1:0] MAX_PROD = MAX_OP * MAX_OP;

    logic          v_line [LAT];
    logic [PW-1:0] p_line [LAT];
    int unsigned   since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                v_line[i] <= 1'b0;
                p_line[i] <= '0;
            end
            since_rst <= 0;
        end else begin
            v_line[0] <= in_valid;
            p_line[0] <= {{N{1'b0}}, op_a} * {{N{1'b0}}, op_b};
            for (int i = 1; i < LAT; i++) begin
                v_line[i] <= v_line[i-1];
                p_line[i] <= p_line[i-1];
            end
            if (since_rst < LAT) since_rst <= since_rst + 1;
        end
    end

    AST_VALID_SLOT:     assert property (@(posedge clk) disable iff (!rst_n) out_valid == v_line[LAT-1]);              // R2
    AST_PRODUCT_VALUE:  assert property (@(posedge clk) disable iff (!rst_n) v_line[LAT-1] |-> product == p_line[LAT-1]); // R1
    AST_QUIET_FILL:     assert property (@(posedge clk) disable iff (!rst_n) (since_rst < LAT) |-> !out_valid);        // R4
    AST_PRODUCT_BOUND:  assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> product <= MAX_PROD);        // R8
endmodule

bind systolic_mult systolic_mult_check #(.N(N)) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/test_systolic_mult.sv
`timescale 1ns/1ps
module test_systolic_mult;
    localparam int N   = 8;
    localparam int PW  = 2 * N;
    localparam int LAT = 3 * N;
    localparam int BURST = 40;
    localparam logic [PW-1:0] MAX_OP = {{N{1'b0}}, {N{1'b1}}};
    localparam logic [PW-1:0] MAX_PROD = MAX_OP * MAX_OP;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [N-1:0]   op_a = '0;
    logic [N-1:0]   op_b = '0;
    logic           out_valid;
    logic [PW-1:0]  product;

    int checks = 0;
    int errors = 0;
    int r3_seen = 0;
    string cur_tag = "R4";

    typedef struct {
        bit            v;
        logic [PW-1:0] p;
        string         tag;
    } exp_t;

    exp_t model_q [$];

    always #2 clk = ~clk;   // 250 MHz

    systolic_mult #(.N(N)) i_systolic_mult (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .product(product)
    );

    task automatic check(input bit ok, input string req,
                         input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: one entry per rising edge.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_q.delete();
        end else begin
            exp_t e;
            e.v   = in_valid;
            e.p   = {{N{1'b0}}, op_a} * {{N{1'b0}}, op_b};
            e.tag = cur_tag;
            model_q.push_back(e);
            if (model_q.size() > LAT) void'(model_q.pop_front());
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            check(out_valid == 1'b0, "R4 reset valid", PW'(out_valid), '0);
            check(product == '0, "R4 reset product", product, '0);
        end else if (model_q.size() == LAT) begin
            exp_t e;
            e = model_q[0];
            check(out_valid == e.v, $sformatf("R2 slot (%s)", e.tag), PW'(out_valid), PW'(e.v));
            if (e.v) begin
                check(product == e.p, $sformatf("R1 value (%s)", e.tag), product, e.p);
                check(product <= MAX_PROD, "R8 bound", product, MAX_PROD);
                if (e.tag == "R3" && out_valid) r3_seen++;
            end
        end else begin
            check(out_valid == 1'b0, "R4 fill", PW'(out_valid), '0);
        end
    end

    task automatic drive(input bit v, input logic [N-1:0] a, input logic [N-1:0] b,
                         input string tag);
        @(negedge clk);
        in_valid = v;
        op_a     = a;
        op_b     = b;
        cur_tag  = tag;
    endtask

    initial begin
        logic [N-1:0] ones;
        logic [N-1:0] top;
        ones = '1;
        top  = '0;
        top[N-1] = 1'b1;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) drive(1'b0, '0, '0, "R4");

        // R7 corner operands, back to back
        drive(1'b1, '0,   '0,   "R7");
        drive(1'b1, ones, ones, "R7");
        drive(1'b1, 1,    ones, "R7");
        drive(1'b1, ones, 1,    "R7");
        drive(1'b1, '0,   ones, "R7");
        drive(1'b1, 1,    1,    "R7");
        drive(1'b1, top,  top,  "R7");
        drive(1'b1, top,  ones, "R7");

        // R3 unbroken burst
        for (int i = 0; i < BURST; i++) begin
            drive(1'b1, N'($urandom), N'($urandom), "R3");
        end

        // R5 invalid cycles with random operands
        for (int i = 0; i < 20; i++) begin
            drive(1'b0, N'($urandom), N'($urandom), "R5");
        end

        // R6 random interleaving of valid and empty slots
        for (int i = 0; i < 300; i++) begin
            drive(1'($urandom), N'($urandom), N'($urandom), "R6");
        end

        // drain
        for (int i = 0; i < LAT + 4; i++) begin
            drive(1'b0, N'($urandom), N'($urandom), "R5");
        end
        @(negedge clk);
        check(r3_seen == BURST, "R3 burst throughput", PW'(r3_seen), PW'(BURST));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R2: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule